// File: doc/BRIEF.md
# Accumulator Readout Formatter

This block turns one 48-bit multiply-accumulate register into the 32-bit word that a move to a general register delivers. The active arithmetic mode decides the conversion. In fractional mode the value is rounded to 16 or 32 bits and can saturate. In signed or unsigned integer mode the value is either passed through or clamped. The accumulator bank stays outside the block, and all of its registers arrive on one flat input bus.

The same port can instead deliver the extension bits of an accumulator pair packed into one word. The flag nibble of the status word is always presented as a five-bit condition code. A read may ask for the selected accumulator to be cleared afterwards. The block then issues a one-cycle clear request, with the index attached, to the storage that owns the register.

In fractional layout a 48-bit value holds a sign byte, a 32-bit body and a low byte. In integer layout it holds a 16-bit extension above a 32-bit body.

Top module: `mac_acc_readout`

## Requirements
- R1: Fractional mode with signed select set: the signed field formed by bits 47..24 is rounded by bits 23..0 and gives a 16-bit result in the low half of `rd_data`, with the upper half zero. A remainder above 0x800000 rounds up. A remainder of exactly 0x800000 rounds up only when the field is odd.
- R2: Fractional mode with signed select clear and rounding enabled: the value shifted right arithmetically by 8 is rounded by bits 7..0. A remainder above 0x80 rounds up. A remainder of exactly 0x80 rounds to the even result.
- R3: Fractional mode with signed select clear and rounding disabled: bits 7..0 are dropped without rounding.
- R4: In fractional mode with overflow-mode set, a rounded result outside the signed 16-bit range (16-bit case) or signed 32-bit range (32-bit case) becomes 0x7FFF / 0x8000 or 0x7FFFFFFF / 0x80000000, chosen by sign. With overflow-mode clear, the low 16 or 32 bits are returned.
- R5: Integer mode with overflow-mode clear returns bits 31..0 of the accumulator unchanged.
- R6: Signed integer mode with overflow-mode set returns 0x7FFFFFFF for values above the signed 32-bit range, 0x80000000 for values below it, and bits 31..0 otherwise.
- R7: Unsigned integer mode with overflow-mode set returns 0xFFFFFFFF when any of bits 47..32 is set, and bits 31..0 otherwise.
- R8: A cycle with `rd_req` and `rd_clr` high and `rd_ext` low produces `clr_req` high for exactly the following cycle, with `clr_idx` equal to that cycle's `rd_idx`. No other cycle raises `clr_req`.
- R9: With `rd_ext` high in an integer mode, `rd_data` holds bits 47..32 of the odd accumulator of the pair in bits 31..16 and bits 47..32 of the even accumulator in bits 15..0. The pair is `rd_idx` with its low bit cleared, plus one.
- R10: With `rd_ext` high in fractional mode, `rd_data` bytes from 31 down to 0 are: odd[47:40], odd[7:0], even[47:40], even[7:0].
- R11: `ccr_o` bit 4 (extend) is always zero, and bits 3..0 equal `stat_flags` (N, Z, V, EV from bit 3 down to bit 0).
- R12: While reset is held and after it is released, `clr_req` is low until a clearing read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_flat | input | NUM_ACC*48 | All accumulators, register i in bits i*48+47..i*48 |
| rd_idx | input | $clog2(NUM_ACC) | Accumulator index (or pair member when rd_ext is high) |
| rd_ext | input | 1 | Read packed extension bits of a pair instead of a value |
| rd_req | input | 1 | Read strobe |
| rd_clr | input | 1 | Ask that the read accumulator be cleared |
| mode_frac | input | 1 | Fractional arithmetic mode |
| mode_su | input | 1 | Signed select (16-bit readout in fractional mode) |
| mode_rt | input | 1 | Rounding enable for 32-bit fractional readout |
| mode_omc | input | 1 | Overflow mode: saturate on readout |
| stat_flags | input | 4 | Status flags N, Z, V, EV |
| rd_data | output | 32 | Formatted readout |
| clr_req | output | 1 | One-cycle clear request |
| clr_idx | output | $clog2(NUM_ACC) | Accumulator to clear |
| ccr_o | output | 5 | Condition codes X, N, Z, V, C |

## Verification
Random 48-bit values are drawn across all mode combinations. Some of them are narrowed to sign-extended 32-bit values so that the unsaturated paths are reached, and others have their remainder forced to exactly half. The forced halves separate ties-to-even from plain round-up and from truncation. Directed values sit at the edges of the signed and unsigned ranges and at a rounding carry that crosses into saturation. These separate clamping from masking. Pair packing uses distinct byte patterns in both pairs, so that swapped halves or lanes and a wrong pair are visible.

// File: rtl/mac_rd_pkg.sv
// Shared widths and readout format codes for the accumulator readout block.
// Assumes a 48-bit accumulator and a 32-bit register file.
package mac_rd_pkg;
    localparam int ACC_W  = 48;
    localparam int DATA_W = 32;
    localparam int EXT_W  = 16;

    typedef enum logic [2:0] {
        FMT_FRAC16,
        FMT_FRAC32,
        FMT_INT_RAW,
        FMT_INT_SGN,
        FMT_INT_UNS,
        FMT_EXT
    } rd_fmt_e;
endpackage

// File: rtl/mac_frac_round.sv
// Fractional readout: drops SHIFT low bits with optional ties-to-even
// rounding, then optionally clamps to the signed OUT_W range.
// Assumes SHIFT >= 2 and IN_W - SHIFT >= OUT_W.
module mac_frac_round #(
    parameter int IN_W  = 48,
    parameter int SHIFT = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  acc_i,
    input  logic             round_en,
    input  logic             sat_en,
    output logic [OUT_W-1:0] res_o
);
    localparam int HW = IN_W - SHIFT;
    localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HW-1:0]    head;
    logic [SHIFT-1:0] rem;
    logic             bump;
    logic [HW:0]      sum;
    logic             fits;

    // Round decision: above half, or exactly half on an odd head.
    always_comb begin
        head = acc_i[IN_W-1:SHIFT];
        rem  = acc_i[SHIFT-1:0];
        bump = round_en && ((rem > HALF) || ((rem == HALF) && head[0]));
        sum  = {head[HW-1], head} + {{HW{1'b0}}, bump};
    end

    // Range test and clamp against the signed output range.
    always_comb begin
        fits  = (&sum[HW:OUT_W-1]) || ~(|sum[HW:OUT_W-1]);
        res_o = sum[OUT_W-1:0];
        if (sat_en && !fits)
            res_o = sum[HW] ? NEG_MIN : POS_MAX;
    end
endmodule

// File: rtl/mac_int_sat.sv
// Integer readout: passes the low word or clamps it to the signed or
// unsigned 32-bit range when overflow mode is active.
// Assumes a 48-bit accumulator in integer layout.
module mac_int_sat
    import mac_rd_pkg::*;
(
    input  logic [ACC_W-1:0]  acc_i,
    input  logic              signed_i,
    input  logic              sat_en,
    output logic [DATA_W-1:0] res_o
);
    logic s_fits;
    logic u_fits;

    // Range tests and clamp selection.
    always_comb begin
        s_fits = (&acc_i[ACC_W-1:DATA_W-1]) || ~(|acc_i[ACC_W-1:DATA_W-1]);
        u_fits = ~(|acc_i[ACC_W-1:DATA_W]);
        res_o  = acc_i[DATA_W-1:0];
        if (sat_en) begin
            if (signed_i && !s_fits)
                res_o = acc_i[ACC_W-1] ? {1'b1, {(DATA_W-1){1'b0}}}
                                       : {1'b0, {(DATA_W-1){1'b1}}};
            else if (!signed_i && !u_fits)
                res_o = {DATA_W{1'b1}};
        end
    end
endmodule

// File: rtl/mac_ext_pack.sv
// Packs the extension bits of an accumulator pair into one word.
// Integer layout uses the 16-bit extensions, fractional layout the
// high and low extension bytes of each register.
module mac_ext_pack
    import mac_rd_pkg::*;
(
    input  logic [EXT_W-1:0]  even_hi_i,
    input  logic [7:0]        even_lo_i,
    input  logic [EXT_W-1:0]  odd_hi_i,
    input  logic [7:0]        odd_lo_i,
    input  logic              frac_i,
    output logic [DATA_W-1:0] word_o
);
    // Lane placement per layout.
    always_comb begin
        if (frac_i)
            word_o = {odd_hi_i[15:8], odd_lo_i, even_hi_i[15:8], even_lo_i};
        else
            word_o = {odd_hi_i, even_hi_i};
    end
endmodule

// File: rtl/mac_acc_readout.sv
// Top of the accumulator readout: selects an accumulator, formats it for
// the active mode, packs pair extensions on request, exports condition
// codes and issues a registered one-cycle clear request.
// Assumes NUM_ACC is even and a power of two, at least 2.
module mac_acc_readout
    import mac_rd_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int IDX_W  = $clog2(NUM_ACC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ACC*ACC_W-1:0] acc_flat,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic                     rd_ext,
    input  logic                     rd_req,
    input  logic                     rd_clr,
    input  logic                     mode_frac,
    input  logic                     mode_su,
    input  logic                     mode_rt,
    input  logic                     mode_omc,
    input  logic [3:0]               stat_flags,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     clr_req,
    output logic [IDX_W-1:0]         clr_idx,
    output logic [4:0]               ccr_o
);
    logic [ACC_W-1:0]  acc_arr [NUM_ACC];
    logic [ACC_W-1:0]  sel_acc;
    logic [ACC_W-1:0]  even_acc;
    logic [ACC_W-1:0]  odd_acc;
    logic [IDX_W-1:0]  even_idx;
    logic [IDX_W-1:0]  odd_idx;
    logic [15:0]       f16_res;
    logic [DATA_W-1:0] f32_res;
    logic [DATA_W-1:0] int_res;
    logic [DATA_W-1:0] ext_res;
    rd_fmt_e           fmt;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ACC; gi++) begin : g_unpack
            assign acc_arr[gi] = acc_flat[gi*ACC_W +: ACC_W];
        end
    endgenerate

    // Accumulator and pair selection.
    always_comb begin
        even_idx = {rd_idx[IDX_W-1:1], 1'b0};
        odd_idx  = {rd_idx[IDX_W-1:1], 1'b1};
        sel_acc  = acc_arr[rd_idx];
        even_acc = acc_arr[even_idx];
        odd_acc  = acc_arr[odd_idx];
    end

    mac_frac_round #(.IN_W(ACC_W), .SHIFT(24), .OUT_W(16)) u_f16 (
        .acc_i    (sel_acc),
        .round_en (1'b1),
        .sat_en   (mode_omc),
        .res_o    (f16_res)
    );

    mac_frac_round #(.IN_W(ACC_W), .SHIFT(8), .OUT_W(DATA_W)) u_f32 (
        .acc_i    (sel_acc),
        .round_en (mode_rt),
        .sat_en   (mode_omc),
        .res_o    (f32_res)
    );

    mac_int_sat u_int (
        .acc_i    (sel_acc),
        .signed_i (mode_su),
        .sat_en   (mode_omc),
        .res_o    (int_res)
    );

    mac_ext_pack u_ext (
        .even_hi_i (even_acc[ACC_W-1:DATA_W]),
        .even_lo_i (even_acc[7:0]),
        .odd_hi_i  (odd_acc[ACC_W-1:DATA_W]),
        .odd_lo_i  (odd_acc[7:0]),
        .frac_i    (mode_frac),
        .word_o    (ext_res)
    );

    // Format decode from the mode bits.
    always_comb begin
        if (rd_ext)         fmt = FMT_EXT;
        else if (mode_frac) fmt = mode_su ? FMT_FRAC16 : FMT_FRAC32;
        else if (!mode_omc) fmt = FMT_INT_RAW;
        else                fmt = mode_su ? FMT_INT_SGN : FMT_INT_UNS;
    end

    // Readout multiplexer.
    always_comb begin
        unique case (fmt)
            FMT_FRAC16: rd_data = {16'h0000, f16_res};
            FMT_FRAC32: rd_data = f32_res;
            FMT_EXT:    rd_data = ext_res;
            default:    rd_data = int_res;
        endcase
    end

    // Condition codes: extend forced low, flag nibble copied.
    always_comb ccr_o = {1'b0, stat_flags};

    // One-cycle clear request after a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_req <= 1'b0;
            clr_idx <= '0;
        end else begin
            clr_req <= rd_req & rd_clr & ~rd_ext;
            clr_idx <= rd_idx;
        end
    end
endmodule

// File: rtl/mac_acc_readout_chk.sv
// Assertion checker for the accumulator readout, bound to the top module.
module mac_acc_readout_chk #(
    parameter int NUM_ACC = 4,
    localparam int IDX_W  = $clog2(NUM_ACC)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_ACC*48-1:0] acc_flat,
    input logic [IDX_W-1:0]      rd_idx,
    input logic                  rd_ext,
    input logic                  rd_req,
    input logic                  rd_clr,
    input logic                  mode_frac,
    input logic                  mode_su,
    input logic                  mode_omc,
    input logic [31:0]           rd_data,
    input logic                  clr_req,
    input logic [IDX_W-1:0]      clr_idx
);
    logic [47:0] sel;
    logic        do_clr;
    always_comb begin
        sel    = acc_flat[rd_idx*48 +: 48];
        do_clr = rd_req && rd_clr && !rd_ext;
    end

    // R8
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> clr_req);
    // R8
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_clr |=> !clr_req);
    // R8
    clr_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> (clr_idx == $past(rd_idx)));
    // R1
    frac16_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ext && mode_frac && mode_su) |-> (rd_data[31:16] == 16'h0));
    // R6
    sgn_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ext && !mode_frac && mode_su && mode_omc) |->
        (rd_data == sel[31:0] || rd_data == 32'h7FFFFFFF || rd_data == 32'h80000000));
    // R7
    uns_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ext && !mode_frac && !mode_su && mode_omc && (sel[47:32] != 16'h0))
        |-> (rd_data == 32'hFFFFFFFF));
    // R5
    int_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ext && !mode_frac && !mode_omc) |-> (rd_data == sel[31:0]));
endmodule

bind mac_acc_readout mac_acc_readout_chk #(.NUM_ACC(NUM_ACC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_flat  (acc_flat),
    .rd_idx    (rd_idx),
    .rd_ext    (rd_ext),
    .rd_req    (rd_req),
    .rd_clr    (rd_clr),
    .mode_frac (mode_frac),
    .mode_su   (mode_su),
    .mode_omc  (mode_omc),
    .rd_data   (rd_data),
    .clr_req   (clr_req),
    .clr_idx   (clr_idx)
);

// File: tb/sim_mac_acc_readout.sv
module sim_mac_acc_readout;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [47:0]  accs [4];
    logic [191:0] acc_flat;
    logic [1:0]   rd_idx = '0;
    logic         rd_ext = 0, rd_req = 0, rd_clr = 0;
    logic         mode_frac = 0, mode_su = 0, mode_rt = 0, mode_omc = 0;
    logic [3:0]   stat_flags = '0;
    logic [31:0]  rd_data;
    logic         clr_req;
    logic [1:0]   clr_idx;
    logic [4:0]   ccr_o;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;
    always_comb acc_flat = {accs[3], accs[2], accs[1], accs[0]};

    mac_acc_readout u0 (
        .clk(clk), .rst_n(rst_n), .acc_flat(acc_flat), .rd_idx(rd_idx),
        .rd_ext(rd_ext), .rd_req(rd_req), .rd_clr(rd_clr),
        .mode_frac(mode_frac), .mode_su(mode_su), .mode_rt(mode_rt),
        .mode_omc(mode_omc), .stat_flags(stat_flags), .rd_data(rd_data),
        .clr_req(clr_req), .clr_idx(clr_idx), .ccr_o(ccr_o)
    );

    function automatic logic [31:0] model_rd(logic [47:0] a, bit fr, bit su, bit rt, bit omc);
        longint s;
        longint h;
        longint rem;
        s = longint'({{16{a[47]}}, a});
        if (fr && su) begin
            h = s >>> 24;
            rem = longint'(a[23:0]);
            if (rem > 64'h800000) h = h + 1;
            else if (rem == 64'h800000) h = h + (h & 1);
            if (omc && (h > 32767 || h < -32768)) return (h < 0) ? 32'h8000 : 32'h7FFF;
            return {16'h0, h[15:0]};
        end else if (fr) begin
            h = s >>> 8;
            rem = longint'(a[7:0]);
            if (rt) begin
                if (rem > 128) h = h + 1;
                else if (rem == 128) h = h + (h & 1);
            end
            if (omc && (h > 64'sd2147483647 || h < -64'sd2147483648))
                return (h < 0) ? 32'h80000000 : 32'h7FFFFFFF;
            return h[31:0];
        end else if (!omc) begin
            return a[31:0];
        end else if (su) begin
            if (s > 64'sd2147483647) return 32'h7FFFFFFF;
            if (s < -64'sd2147483648) return 32'h80000000;
            return a[31:0];
        end
        return (a[47:32] != 0) ? 32'hFFFFFFFF : a[31:0];
    endfunction

    function automatic logic [31:0] model_ext(logic [47:0] ev, logic [47:0] od, bit fr);
        if (fr) return {od[47:40], od[7:0], ev[47:40], ev[7:0]};
        return {od[47:32], ev[47:32]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(bit fr, bit su, bit rt, bit omc);
        mode_frac = fr; mode_su = su; mode_rt = rt; mode_omc = omc;
    endtask

    task automatic dir(string req, logic [47:0] a, bit fr, bit su, bit rt, bit omc, logic [31:0] exp);
        @(negedge clk);
        accs[1] = a; rd_idx = 2'd1; rd_ext = 0;
        set_mode(fr, su, rt, omc);
        #1 chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        logic [47:0] a;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) accs[i] = '0;
        repeat (3) @(negedge clk);
        // R12: clear request low during reset
        chk("R12", {31'h0, clr_req}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R12", {31'h0, clr_req}, 32'h0);

        // R1 ties-to-even at 16 bits
        dir("R1", 48'h0000_0280_0000, 1, 1, 0, 0, 32'h0000_0002);
        dir("R1", 48'h0000_0380_0000, 1, 1, 0, 0, 32'h0000_0004);
        dir("R1", 48'h0000_0280_0001, 1, 1, 0, 0, 32'h0000_0003);
        // R2 ties-to-even at 32 bits
        dir("R2", 48'h0000_0000_0180, 1, 0, 1, 0, 32'h0000_0002);
        dir("R2", 48'h0000_0000_0280, 1, 0, 1, 0, 32'h0000_0002);
        dir("R2", 48'h0000_0000_0281, 1, 0, 1, 0, 32'h0000_0003);
        // R3 truncation
        dir("R3", 48'h0000_0000_01FF, 1, 0, 0, 0, 32'h0000_0001);
        // R4 fractional saturation and masking
        dir("R4", 48'h7F00_0000_0000, 1, 0, 0, 1, 32'h7FFF_FFFF);
        dir("R4", 48'h8000_0000_0000, 1, 0, 0, 1, 32'h8000_0000);
        dir("R4", 48'h7F12_3456_7800, 1, 0, 0, 0, 32'h1234_5678);
        dir("R4", 48'h0100_0000_0000, 1, 1, 0, 1, 32'h0000_7FFF);
        dir("R4", 48'h007F_FFFF_0000, 1, 1, 0, 1, 32'h0000_7FFF);
        dir("R4", 48'h007F_FFFF_0000, 1, 1, 0, 0, 32'h0000_8000);
        dir("R4", 48'hFF00_0000_0000, 1, 1, 0, 1, 32'h0000_8000);
        // R5 raw integer
        dir("R5", 48'hABCD_1234_5678, 0, 1, 0, 0, 32'h1234_5678);
        // R6 signed clamp
        dir("R6", 48'h0000_8000_0000, 0, 1, 0, 1, 32'h7FFF_FFFF);
        dir("R6", 48'hFFFF_7FFF_FFFF, 0, 1, 0, 1, 32'h8000_0000);
        dir("R6", 48'hFFFF_FFFF_FFFE, 0, 1, 0, 1, 32'hFFFF_FFFE);
        // R7 unsigned clamp
        dir("R7", 48'h0001_0000_0000, 0, 0, 0, 1, 32'hFFFF_FFFF);
        dir("R7", 48'h0000_FFFF_0000, 0, 0, 0, 1, 32'hFFFF_0000);

        // R1..R7 random sweep against the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                a = {$urandom(), $urandom()} ;
                if ($urandom_range(0, 2) == 0) a = {{16{a[31]}}, a[31:0]};
                if ($urandom_range(0, 3) == 0) a[23:0] = 24'h800000;
                if ($urandom_range(0, 3) == 0) a[7:0] = 8'h80;
                accs[k] = a;
            end
            rd_idx = 2'($urandom_range(0, 3));
            rd_ext = 0;
            set_mode(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
            #1;
            if (mode_frac && mode_su) chk("R1", rd_data, model_rd(accs[rd_idx], 1, 1, mode_rt, mode_omc));
            else if (mode_frac && mode_rt) chk("R2", rd_data, model_rd(accs[rd_idx], 1, 0, 1, mode_omc));
            else if (mode_frac) chk("R3", rd_data, model_rd(accs[rd_idx], 1, 0, 0, mode_omc));
            else if (!mode_omc) chk("R5", rd_data, model_rd(accs[rd_idx], 0, mode_su, mode_rt, 0));
            else if (mode_su) chk("R6", rd_data, model_rd(accs[rd_idx], 0, 1, mode_rt, 1));
            else chk("R7", rd_data, model_rd(accs[rd_idx], 0, 0, mode_rt, 1));
        end

        // R9 / R10 directed pair packing
        @(negedge clk);
        accs[0] = 48'h1111_2222_3333; accs[1] = 48'h4444_5555_6666;
        accs[2] = 48'h7788_99AA_BBCC; accs[3] = 48'hDDEE_F012_3456;
        rd_ext = 1; rd_idx = 2'd1; set_mode(0, 1, 0, 1);
        #1 chk("R9", rd_data, 32'h4444_1111);
        rd_idx = 2'd2;
        #1 chk("R9", rd_data, 32'hDDEE_7788);
        mode_frac = 1; rd_idx = 2'd0;
        #1 chk("R10", rd_data, 32'h4466_1133);
        rd_idx = 2'd3;
        #1 chk("R10", rd_data, 32'hDD56_77CC);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) accs[k] = {$urandom(), $urandom()};
            rd_idx = 2'($urandom_range(0, 3));
            set_mode(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
            #1 chk(mode_frac ? "R10" : "R9", rd_data,
                   model_ext(accs[{rd_idx[1], 1'b0}], accs[{rd_idx[1], 1'b1}], mode_frac));
        end

        // R11 condition codes
        for (int f = 0; f < 16; f++) begin
            stat_flags = 4'(f);
            #1 chk("R11", {27'h0, ccr_o}, {28'h0, 4'(f)});
        end

        // R8 clear pulse
        @(negedge clk);
        rd_ext = 0; rd_idx = 2'd2; rd_req = 1; rd_clr = 1;
        @(negedge clk);
        rd_req = 0; rd_clr = 0;
        chk("R8", {29'h0, clr_req, clr_idx}, {29'h0, 1'b1, 2'd2});
        @(negedge clk);
        chk("R8", {31'h0, clr_req}, 32'h0);
        // R8 read without clear: no pulse
        rd_req = 1; rd_clr = 0; rd_idx = 2'd3;
        @(negedge clk);
        chk("R8", {31'h0, clr_req}, 32'h0);
        // R8 extension read with clear: no pulse
        rd_ext = 1; rd_clr = 1;
        @(negedge clk);
        chk("R8", {31'h0, clr_req}, 32'h0);
        // R8 clear flag without strobe: no pulse
        rd_ext = 0; rd_req = 0;
        @(negedge clk);
        chk("R8", {31'h0, clr_req}, 32'h0);
        rd_req = 1; rd_idx = 2'd3;
        @(negedge clk);
        rd_req = 0; rd_clr = 0;
        chk("R8", {29'h0, clr_req, clr_idx}, {29'h0, 1'b1, 2'd3});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule